// File: doc/BRIEF.md
# Ordered Multi-Channel Mailbox FIFO

This block carries payload words from a sending agent to a receiving agent over a set of independent FIFO channels. Each channel keeps its words in strict arrival order. The sender may queue several words without waiting, as long as the channel has room. Each word carries a request bit. When the receiver consumes a word whose bit is set, a level interrupt is raised back toward the sender, and it stays raised until the sender clears it.

Every channel drives level-sensitive interrupts:
- a transfer-pending line toward the receiver;
- a low-tide line and a high-tide line, each compared against its own programmable level;
- a flush-done status bit;
- sticky overflow and underflow error bits.

All tide and flush sources from all channels are ORed onto one combined line. Either side can flush a channel, which empties it in a single cycle. The channel count and the common depth are presented on constant read-back outputs.

Pushes and pops are addressed by a channel index. Read data is returned combinationally in the same cycle as the pop strobe. Storage, pointers and status update on the following rising clock edge.

Top module: `msg_fifo_mbox`

## Requirements
- R1: A push to a channel that is not full and not being flushed stores the word and its request bit, raising that channel's occupancy by one at the next edge. Up to DEPTH words may be queued with no pop in between.
- R2: A pop to a non-empty channel that is not being flushed returns the oldest stored word on `rcv_data` in the same cycle. Words leave each channel in exactly the order they were pushed, and channels do not disturb one another.
- R3: `irq_xfer[c]` is high exactly while channel c holds at least one word.
- R4: Popping a word whose request bit is 1 sets `irq_ack[c]` from the next edge until a `clr_ack[c]` pulse. Popping a word with the bit at 0 leaves it unchanged.
- R5: `irq_low_tide[c]` is high while the occupancy of channel c is less than or equal to `low_tide_lvl`.
- R6: `irq_high_tide[c]` is high while the occupancy of channel c is greater than or equal to `high_tide_lvl`.
- R7: A flush of channel c, from `flush_snd[c]` or `flush_rcv[c]`, has the following effects:
  - At the next edge the channel is empty and its contents are discarded.
  - `irq_flush[c]` rises and holds until a `clr_flush[c]` pulse.
  - A push in the flush cycle is discarded.
  - A pop in the flush cycle returns zero and raises no underflow.
- R8: A push to a full channel is dropped, leaving the stored words unchanged, and sets the sticky `err_ovf[c]` until a `clr_err[c]` pulse.
- R9: A pop from an empty channel returns zero and sets the sticky `err_unf[c]` until a `clr_err[c]` pulse.
- R10: `irq_fifo_comb` is the OR, over all channels, of the low-tide, high-tide and flush-status lines.
- R11: `cfg_num_ch` reads NUM_CH and `cfg_depth` reads DEPTH at all times.
- R12: After reset every channel is empty, and the request, flush, overflow and underflow status bits are all 0. If a set event and a clear pulse for a status bit arrive in the same cycle, the set wins.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| snd_push | input | 1 | Push strobe from the sender |
| snd_ch | input | CH_W | Channel addressed by the push |
| snd_data | input | DATA_W | Payload word to push |
| snd_ack_req | input | 1 | Request bit stored with the pushed word |
| rcv_pop | input | 1 | Pop strobe from the receiver |
| rcv_ch | input | CH_W | Channel addressed by the pop |
| rcv_data | output | DATA_W | Popped word, same cycle; zero when no word is taken |
| flush_snd | input | NUM_CH | Per-channel flush request from the sender |
| flush_rcv | input | NUM_CH | Per-channel flush request from the receiver |
| low_tide_lvl | input | CNT_W | Low-tide level shared by all channels |
| high_tide_lvl | input | CNT_W | High-tide level shared by all channels |
| clr_ack | input | NUM_CH | Clear pulses for the acknowledge status |
| clr_flush | input | NUM_CH | Clear pulses for the flush status |
| clr_err | input | NUM_CH | Clear pulses for both error bits |
| irq_xfer | output | NUM_CH | Transfer pending, toward the receiver |
| irq_ack | output | NUM_CH | Acknowledge status, toward the sender |
| irq_low_tide | output | NUM_CH | Low-tide level interrupt |
| irq_high_tide | output | NUM_CH | High-tide level interrupt |
| irq_flush | output | NUM_CH | Flush-done status |
| irq_fifo_comb | output | 1 | Combined tide and flush interrupt |
| err_ovf | output | NUM_CH | Sticky overflow error |
| err_unf | output | NUM_CH | Sticky underflow error |
| cfg_num_ch | output | 7 | Channel count read-back |
| cfg_depth | output | CNT_W | Depth read-back |

## Verification
A corrupted read pointer or storage word shows up on `rcv_data` in the very cycle of the next pop, as a word out of order or a stale word. A wrong occupancy count is seen one edge after the faulty push or pop: it shifts the tide lines at a threshold boundary, drops `irq_xfer` too early or too late, or misplaces the overflow point at DEPTH. A lost request bit or a missed flush appears one edge after the pop or flush on `irq_ack` or `irq_flush`. The combined line exposes any stray tide or flush level as soon as every channel sits between the two levels.

// File: rtl/msg_fifo_pkg.sv
// Package: shared types for the ordered mailbox FIFO.
// Assumes nothing beyond standard SystemVerilog.
package msg_fifo_pkg;

    // Per-channel sticky status bits
    typedef struct packed {
        logic ack;
        logic flushed;
        logic ovf;
        logic unf;
    } chan_sts_t;

    // Index width that never collapses to zero
    function automatic int unsigned idx_w(input int unsigned n);
        return (n > 1) ? $clog2(n) : 1;
    endfunction

endpackage

// File: rtl/mfifo_tide.sv
// Module: mfifo_tide
// Compares one channel's occupancy against the low and high tide levels.
// Assumes: levels are held stable by the owner; outputs are pure levels.
module mfifo_tide #(
    parameter int unsigned CNT_W = 4
) (
    input  logic [CNT_W-1:0] occ,
    input  logic [CNT_W-1:0] low_lvl,
    input  logic [CNT_W-1:0] high_lvl,
    output logic             low_hit,
    output logic             high_hit
);

    // Threshold comparisons, inclusive at both levels
    always_comb begin
        low_hit  = (occ <= low_lvl);
        high_hit = (occ >= high_lvl);
    end

endmodule

// File: rtl/mfifo_chan.sv
// Module: mfifo_chan
// One FIFO channel: ordered storage of word plus request bit, occupancy,
// flush, sticky status. Assumes push/pop strobes are already decoded for
// this channel; flush has priority over push and pop in the same cycle.
module mfifo_chan
    import msg_fifo_pkg::*;
#(
    parameter int unsigned DEPTH  = 8,
    parameter int unsigned DATA_W = 32,
    parameter int unsigned CNT_W  = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              push,
    input  logic [DATA_W-1:0] push_data,
    input  logic              push_ack,
    input  logic              pop,
    input  logic              flush,
    input  logic              clr_ack,
    input  logic              clr_flush,
    input  logic              clr_err,
    output logic [DATA_W-1:0] rd_data,
    output logic [CNT_W-1:0]  occ,
    output chan_sts_t         sts
);

    localparam int unsigned PTR_W = idx_w(DEPTH);
    localparam int unsigned ENT_W = DATA_W + 1;

    logic [ENT_W-1:0] mem [DEPTH];
    logic [PTR_W-1:0] wr_ptr;
    logic [PTR_W-1:0] rd_ptr;
    logic             is_empty;
    logic             is_full;
    logic             push_ok;
    logic             pop_ok;
    logic [ENT_W-1:0] head;

    // Wrap a pointer at DEPTH, which need not be a power of two
    function automatic logic [PTR_W-1:0] step(input logic [PTR_W-1:0] p);
        return (p == PTR_W'(DEPTH - 1)) ? '0 : p + 1'b1;
    endfunction

    // Accept/reject decisions for this cycle
    always_comb begin
        is_empty = (occ == '0);
        is_full  = (occ == CNT_W'(DEPTH));
        push_ok  = push && !flush && !is_full;
        pop_ok   = pop && !flush && !is_empty;
        head     = mem[rd_ptr];
        rd_data  = pop_ok ? head[DATA_W-1:0] : '0;
    end

    // Storage write; contents need no reset because occupancy guards reads
    always_ff @(posedge clk) begin
        if (push_ok) begin
            mem[wr_ptr] <= {push_ack, push_data};
        end
    end

    // Pointers and occupancy; flush empties the channel in one cycle
    always_ff @(posedge clk) begin
        if (!rst_n || flush) begin
            wr_ptr <= '0;
            rd_ptr <= '0;
            occ    <= '0;
        end else begin
            if (push_ok) wr_ptr <= step(wr_ptr);
            if (pop_ok)  rd_ptr <= step(rd_ptr);
            case ({push_ok, pop_ok})
                2'b10:   occ <= occ + 1'b1;
                2'b01:   occ <= occ - 1'b1;
                default: occ <= occ;
            endcase
        end
    end

    // Sticky status bits; a set event outranks a clear pulse
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sts <= '0;
        end else begin
            sts.ack     <= (sts.ack & ~clr_ack) | (pop_ok & head[DATA_W]);
            sts.flushed <= (sts.flushed & ~clr_flush) | flush;
            sts.ovf     <= (sts.ovf & ~clr_err) | (push & ~flush & is_full);
            sts.unf     <= (sts.unf & ~clr_err) | (pop & ~flush & is_empty);
        end
    end

    AST_OCC_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
        occ <= CNT_W'(DEPTH)); // R1

    AST_PUSH_GROWS: assert property (@(posedge clk) disable iff (!rst_n)
        (push && !flush && !is_full && !pop) |=> (occ == $past(occ) + 1'b1)); // R1

    AST_FLUSH_EMPTIES: assert property (@(posedge clk) disable iff (!rst_n)
        flush |=> (occ == '0 && sts.flushed)); // R7

    AST_OVF_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        (push && !flush && is_full) |=> sts.ovf); // R8

    AST_UNF_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        (pop && !flush && is_empty) |=> sts.unf); // R9

    AST_ACK_RAISE: assert property (@(posedge clk) disable iff (!rst_n)
        (pop_ok && head[DATA_W]) |=> sts.ack); // R4

    AST_FULL_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        (is_full && push && !pop && !flush) |=> $stable(occ)); // R8

endmodule

// File: rtl/msg_fifo_mbox.sv
// Module: msg_fifo_mbox (top)
// Array of ordered FIFO channels between a sender and a receiver, with
// per-channel tide, flush, acknowledge and error indications.
// Assumes: 1 <= NUM_CH <= 64; indices >= NUM_CH address no channel.
module msg_fifo_mbox
    import msg_fifo_pkg::*;
#(
    parameter int unsigned NUM_CH = 4,
    parameter int unsigned DEPTH  = 8,
    parameter int unsigned DATA_W = 32,
    localparam int unsigned CH_W  = idx_w(NUM_CH),
    localparam int unsigned CNT_W = $clog2(DEPTH + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              snd_push,
    input  logic [CH_W-1:0]   snd_ch,
    input  logic [DATA_W-1:0] snd_data,
    input  logic              snd_ack_req,
    input  logic              rcv_pop,
    input  logic [CH_W-1:0]   rcv_ch,
    output logic [DATA_W-1:0] rcv_data,
    input  logic [NUM_CH-1:0] flush_snd,
    input  logic [NUM_CH-1:0] flush_rcv,
    input  logic [CNT_W-1:0]  low_tide_lvl,
    input  logic [CNT_W-1:0]  high_tide_lvl,
    input  logic [NUM_CH-1:0] clr_ack,
    input  logic [NUM_CH-1:0] clr_flush,
    input  logic [NUM_CH-1:0] clr_err,
    output logic [NUM_CH-1:0] irq_xfer,
    output logic [NUM_CH-1:0] irq_ack,
    output logic [NUM_CH-1:0] irq_low_tide,
    output logic [NUM_CH-1:0] irq_high_tide,
    output logic [NUM_CH-1:0] irq_flush,
    output logic              irq_fifo_comb,
    output logic [NUM_CH-1:0] err_ovf,
    output logic [NUM_CH-1:0] err_unf,
    output logic [6:0]        cfg_num_ch,
    output logic [CNT_W-1:0]  cfg_depth
);

    logic [DATA_W-1:0] ch_rd  [NUM_CH];
    logic [CNT_W-1:0]  ch_occ [NUM_CH];
    chan_sts_t         ch_sts [NUM_CH];

    for (genvar g = 0; g < NUM_CH; g++) begin : g_ch
        logic push_sel;
        logic pop_sel;

        // Address decode of the shared push and pop strobes
        always_comb begin
            push_sel = snd_push && (snd_ch == CH_W'(g));
            pop_sel  = rcv_pop && (rcv_ch == CH_W'(g));
        end

        mfifo_chan #(
            .DEPTH  (DEPTH),
            .DATA_W (DATA_W),
            .CNT_W  (CNT_W)
        ) u_chan (
            .clk       (clk),
            .rst_n     (rst_n),
            .push      (push_sel),
            .push_data (snd_data),
            .push_ack  (snd_ack_req),
            .pop       (pop_sel),
            .flush     (flush_snd[g] | flush_rcv[g]),
            .clr_ack   (clr_ack[g]),
            .clr_flush (clr_flush[g]),
            .clr_err   (clr_err[g]),
            .rd_data   (ch_rd[g]),
            .occ       (ch_occ[g]),
            .sts       (ch_sts[g])
        );

        mfifo_tide #(
            .CNT_W (CNT_W)
        ) u_tide (
            .occ      (ch_occ[g]),
            .low_lvl  (low_tide_lvl),
            .high_lvl (high_tide_lvl),
            .low_hit  (irq_low_tide[g]),
            .high_hit (irq_high_tide[g])
        );

        // Map channel state onto the per-channel output lines
        always_comb begin
            irq_xfer[g]  = (ch_occ[g] != '0);
            irq_ack[g]   = ch_sts[g].ack;
            irq_flush[g] = ch_sts[g].flushed;
            err_ovf[g]   = ch_sts[g].ovf;
            err_unf[g]   = ch_sts[g].unf;
        end
    end

    // Return data of the addressed channel
    always_comb begin
        rcv_data = '0;
        for (int i = 0; i < NUM_CH; i++) begin
            if (rcv_ch == CH_W'(i)) rcv_data = ch_rd[i];
        end
    end

    // Combined interrupt and constant read-back
    always_comb begin
        irq_fifo_comb = (|irq_low_tide) | (|irq_high_tide) | (|irq_flush);
        cfg_num_ch    = 7'(NUM_CH);
        cfg_depth     = CNT_W'(DEPTH);
    end

    AST_XFER_NOT_ACK_FLUSH: assert property (@(posedge clk) disable iff (!rst_n)
        (|(flush_snd | flush_rcv)) |=> ((irq_xfer & $past(flush_snd | flush_rcv)) == '0)); // R3

endmodule

// File: tb/msg_fifo_mbox_bench.sv
// Directed bench for msg_fifo_mbox: one task per scenario, each checking
// its own results. Inputs change at falling edges only.
module msg_fifo_mbox_bench;

    localparam int unsigned NUM_CH = 4;
    localparam int unsigned DEPTH  = 8;
    localparam int unsigned DATA_W = 32;
    localparam int unsigned CH_W   = 2;
    localparam int unsigned CNT_W  = 4;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              snd_push = 1'b0;
    logic [CH_W-1:0]   snd_ch = '0;
    logic [DATA_W-1:0] snd_data = '0;
    logic              snd_ack_req = 1'b0;
    logic              rcv_pop = 1'b0;
    logic [CH_W-1:0]   rcv_ch = '0;
    logic [DATA_W-1:0] rcv_data;
    logic [NUM_CH-1:0] flush_snd = '0;
    logic [NUM_CH-1:0] flush_rcv = '0;
    logic [CNT_W-1:0]  low_tide_lvl = 4'd2;
    logic [CNT_W-1:0]  high_tide_lvl = 4'd6;
    logic [NUM_CH-1:0] clr_ack = '0;
    logic [NUM_CH-1:0] clr_flush = '0;
    logic [NUM_CH-1:0] clr_err = '0;
    logic [NUM_CH-1:0] irq_xfer, irq_ack, irq_low_tide, irq_high_tide, irq_flush;
    logic [NUM_CH-1:0] err_ovf, err_unf;
    logic              irq_fifo_comb;
    logic [6:0]        cfg_num_ch;
    logic [CNT_W-1:0]  cfg_depth;

    int n_chk  = 0;
    int n_fail = 0;
    bit done   = 1'b0;

    always #10 clk = ~clk;   // 50 MHz

    msg_fifo_mbox #(.NUM_CH(NUM_CH), .DEPTH(DEPTH), .DATA_W(DATA_W)) u_msg_fifo_mbox (
        .clk(clk), .rst_n(rst_n),
        .snd_push(snd_push), .snd_ch(snd_ch), .snd_data(snd_data), .snd_ack_req(snd_ack_req),
        .rcv_pop(rcv_pop), .rcv_ch(rcv_ch), .rcv_data(rcv_data),
        .flush_snd(flush_snd), .flush_rcv(flush_rcv),
        .low_tide_lvl(low_tide_lvl), .high_tide_lvl(high_tide_lvl),
        .clr_ack(clr_ack), .clr_flush(clr_flush), .clr_err(clr_err),
        .irq_xfer(irq_xfer), .irq_ack(irq_ack), .irq_low_tide(irq_low_tide),
        .irq_high_tide(irq_high_tide), .irq_flush(irq_flush), .irq_fifo_comb(irq_fifo_comb),
        .err_ovf(err_ovf), .err_unf(err_unf), .cfg_num_ch(cfg_num_ch), .cfg_depth(cfg_depth)
    );

    task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic push(input int ch, input logic [31:0] d, input logic ack);
        snd_push = 1'b1; snd_ch = CH_W'(ch); snd_data = d; snd_ack_req = ack;
        @(negedge clk);
        snd_push = 1'b0; snd_ack_req = 1'b0;
    endtask

    task automatic pop_chk(input int ch, input logic [31:0] exp, input string tag);
        rcv_pop = 1'b1; rcv_ch = CH_W'(ch);
        #1 chk(tag, 64'(rcv_data), 64'(exp));
        @(negedge clk);
        rcv_pop = 1'b0;
    endtask

    task automatic t_reset;
        chk("R12 xfer after reset", 64'(irq_xfer), 64'h0);
        chk("R12 status after reset", 64'({irq_ack, irq_flush, err_ovf, err_unf}), 64'h0);
        chk("R5 low tide when empty", 64'(irq_low_tide), 64'hF);
        chk("R6 high tide when empty", 64'(irq_high_tide), 64'h0);
        chk("R11 channel count", 64'(cfg_num_ch), 64'd4);
        chk("R11 depth", 64'(cfg_depth), 64'd8);
    endtask

    task automatic t_order;
        for (int i = 0; i < 5; i++) push(1, 32'h1000 + 32'(i * 7), 1'b0);
        chk("R3 xfer set ch1", 64'(irq_xfer), 64'h2);
        for (int i = 0; i < 5; i++) pop_chk(1, 32'h1000 + 32'(i * 7), "R2 order ch1");
        chk("R3 xfer cleared ch1", 64'(irq_xfer), 64'h0);
    endtask

    task automatic t_tide;
        for (int n = 1; n <= 8; n++) begin
            push(2, 32'hB00 + 32'(n), 1'b0);
            chk("R5 low tide ch2", 64'(irq_low_tide[2]), 64'(n <= 2));
            chk("R6 high tide ch2", 64'(irq_high_tide[2]), 64'(n >= 6));
        end
        for (int n = 1; n <= 8; n++) pop_chk(2, 32'hB00 + 32'(n), "R1 full-depth order ch2");
    endtask

    task automatic t_ack;
        push(0, 32'hA0, 1'b0);
        push(0, 32'hA1, 1'b1);
        pop_chk(0, 32'hA0, "R2 ack test first word");
        chk("R4 no ack for plain word", 64'(irq_ack), 64'h0);
        pop_chk(0, 32'hA1, "R2 ack test second word");
        chk("R4 ack raised", 64'(irq_ack), 64'h1);
        clr_ack = 4'h1; @(negedge clk); clr_ack = '0;
        chk("R4 ack cleared", 64'(irq_ack), 64'h0);
    endtask

    task automatic t_overflow;
        for (int i = 0; i < 9; i++) push(3, 32'h300 + 32'(i), 1'b0);
        chk("R8 overflow flag", 64'(err_ovf), 64'h8);
        for (int i = 0; i < 8; i++) pop_chk(3, 32'h300 + 32'(i), "R8 contents kept");
        chk("R8 dropped word absent", 64'(irq_xfer[3]), 64'h0);
        clr_err = 4'h8; @(negedge clk); clr_err = '0;
        chk("R8 overflow cleared", 64'(err_ovf), 64'h0);
    endtask

    task automatic t_underflow;
        pop_chk(3, 32'h0, "R9 empty pop returns zero");
        chk("R9 underflow flag", 64'(err_unf), 64'h8);
        clr_err = 4'h8; @(negedge clk); clr_err = '0;
        chk("R9 underflow cleared", 64'(err_unf), 64'h0);
    endtask

    task automatic t_flush;
        for (int i = 0; i < 3; i++) push(1, 32'h77 + 32'(i), 1'b0);
        flush_rcv = 4'h2; snd_push = 1'b1; snd_ch = 2'd1; snd_data = 32'hDEAD;
        rcv_pop = 1'b1; rcv_ch = 2'd1;
        #1 chk("R7 pop during flush returns zero", 64'(rcv_data), 64'h0);
        @(negedge clk);
        flush_rcv = '0; snd_push = 1'b0; rcv_pop = 1'b0;
        chk("R7 channel emptied", 64'(irq_xfer[1]), 64'h0);
        chk("R7 flush status", 64'(irq_flush), 64'h2);
        chk("R7 no error from flush cycle", 64'({err_ovf, err_unf}), 64'h0);
        push(1, 32'hA5, 1'b0);
        pop_chk(1, 32'hA5, "R7 only post-flush word remains");
        chk("R7 single word after flush", 64'(irq_xfer[1]), 64'h0);
        push(2, 32'h55, 1'b0);
        flush_snd = 4'h4; clr_flush = 4'h2;
        @(negedge clk);
        flush_snd = '0; clr_flush = '0;
        chk("R7 sender flush and clear", 64'(irq_flush), 64'h4);
        chk("R7 sender flush empties", 64'(irq_xfer), 64'h0);
        flush_snd = 4'h4; clr_flush = 4'h4;
        @(negedge clk);
        flush_snd = '0; clr_flush = '0;
        chk("R12 set beats clear", 64'(irq_flush), 64'h4);
        clr_flush = 4'h4; @(negedge clk); clr_flush = '0;
        chk("R7 flush status cleared", 64'(irq_flush), 64'h0);
    endtask

    task automatic t_comb;
        low_tide_lvl = 4'd1; high_tide_lvl = 4'd8;
        for (int c = 0; c < 4; c++) begin
            push(c, 32'(c), 1'b0);
            push(c, 32'(c + 10), 1'b0);
        end
        chk("R10 combined idle between levels", 64'(irq_fifo_comb), 64'h0);
        chk("R3 all channels pending", 64'(irq_xfer), 64'hF);
        flush_snd = 4'h8; @(negedge clk); flush_snd = '0;
        chk("R10 combined from flush", 64'(irq_fifo_comb), 64'h1);
        pop_chk(0, 32'h0, "R2 ch0 untouched by ch3 flush");
        pop_chk(0, 32'd10, "R2 ch0 second word");
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_order();
        t_tide();
        t_ack();
        t_overflow();
        t_underflow();
        t_flush();
        t_comb();
        if (!done) begin
            done = 1'b1;
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        #(20 * 100000);
        if (!done) begin
            done = 1'b1;
            n_chk++; n_fail++;
            $display("FAIL watchdog expired actual=running expected=done");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
            $finish;
        end
    end

endmodule